// File: doc/BRIEF.md
# Oversampled DDR Read Data Recovery

This block turns a strobe and a byte-wide double data rate bus into recovered bytes. The strobe changes state together with the data, so it cannot sample the data directly. A front end captures the strobe and every data line at a fixed rate of six samples per memory clock period, which gives three samples per bit. On each system clock it hands over one six-sample group. The block looks for transitions of the sampled strobe. Both rising and falling transitions count, and each one opens a new byte. The block keeps the data sample one position after each transition, because that sample lies in the middle of the bit. No delay line, training run or calibration step is involved.

A transition can fall on any sample position, including the boundary between two groups. Timing jitter can move it by one sample. In any cycle there may be no byte, one byte or two bytes to deliver. In rare cases there are three, and the third is held over to the next cycle. Bytes always leave in the order they arrived, on a 16-bit output with a two-bit valid mask. An enable marks the read window. A sticky flag reports a strobe that has stopped toggling inside the window.

Top module: `ovs_ddr_recover`

## Requirements
- R1: While reset is asserted and after it is released, `rd_vld_o` is 00 and `gap_err_o` is 0.
- R2: Sample 0 of `strb_smp_i` is the oldest sample of the group. A strobe transition of either polarity between sample k-1 and sample k, for k from 1 to 4, yields the data byte at sample k+1 (`dq_smp_i[8(k+1)+7:8(k+1)]`). This byte appears on the output register in the cycle after the group is presented.
- R3: A transition at sample 5 yields the byte at sample 0 of the next group. That byte is output one cycle after the next group is presented.
- R4: Strobe sample 0 is compared with sample 5 of the previous group, so a transition across the group boundary yields the byte at sample 1.
- R5: The earlier byte is placed in `rd_data_o[7:0]` and the later byte in `rd_data_o[15:8]`. `rd_vld_o` takes only the values 00, 01 (low byte only) and 11.
- R6: When one group holds three bit centers, the first two are output together. The third is output alone in `rd_data_o[7:0]` on the next cycle, ahead of any newer byte.
- R7: While `win_en_i` is low, `rd_vld_o` is 00 on the following cycle, and the strobe history is cleared to low. The first group of a new window is therefore compared against a low level.
- R8: If the strobe shows no transition for more than 12 consecutive samples while `win_en_i` is high, `gap_err_o` rises one cycle after the group that exceeds that limit. The flag stays high while `win_en_i` stays high. It clears one cycle after `win_en_i` goes low.
- R9: Random byte streams are recovered without error at every start offset from 0 to 5 samples. This holds both without jitter and with each strobe edge delayed by 0 or 1 sample at random.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| win_en_i | input | 1 | Read window enable |
| strb_smp_i | input | 6 | Strobe samples, bit 0 oldest |
| dq_smp_i | input | 48 | Data samples, sample i in bits [8i+7:8i] |
| rd_data_o | output | 16 | Recovered bytes, earlier byte low |
| rd_vld_o | output | 2 | Byte-valid mask |
| gap_err_o | output | 1 | Sticky missing-strobe error |

## Verification
A bit center that lies inside the current group shows up on the outputs exactly one clock after the group is applied. A center carried over from sample 5, or a third byte that was held back, shows up one clock later than that. A gap error shows up one clock after the group that pushes the silent run past 12 samples. The bench drives each group just after a rising edge and reads the registered outputs before it applies the next group. Every directed check therefore looks at the result of a known group or of the group right before it. The random streams collect every valid lane at the falling edge and compare the full sequence in order, so the timing of the check does not depend on which cycle a byte lands in.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  parameter int unsigned OVS_SMP_DEF = 6;
  parameter int unsigned OVS_DW_DEF  = 8;
  parameter int unsigned OVS_GAP_DEF = 2 * OVS_SMP_DEF;
endpackage

// File: rtl/ovs_edge.sv
module ovs_edge #(
  parameter int unsigned SMP = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [SMP-1:0] strb_i,
  output logic [SMP-1:0] edge_o
);
  logic last_q, last_d;

  assign edge_o[0] = strb_i[0] ^ last_q;
  for (genvar k = 1; k < SMP; k++) begin : g_edge
    assign edge_o[k] = strb_i[k] ^ strb_i[k-1];
  end

  always_comb begin
    last_d = en_i ? strb_i[SMP-1] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= last_d;
  end

  // R4: the first sample is compared with the final sample of the previous group
  a_r4_boundary_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (edge_o[0] == (strb_i[0] ^ $past(strb_i[SMP-1]))));
endmodule

// File: rtl/ovs_gapmon.sv
module ovs_gapmon #(
  parameter int unsigned SMP = 6,
  parameter int unsigned LIM = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [SMP-1:0] edge_i,
  output logic           err_o
);
  localparam int unsigned CW = $clog2(LIM + SMP + 1);

  logic [CW-1:0] gap_q, gap_d;
  logic          err_q, err_d;
  logic [CW-1:0] last_idx;

  always_comb begin
    last_idx = '0;
    for (int k = 0; k < SMP; k++) begin
      if (edge_i[k]) last_idx = CW'(k);
    end
    if (|edge_i)            gap_d = CW'(SMP - 1) - last_idx;
    else if (gap_q > CW'(LIM)) gap_d = gap_q;
    else                    gap_d = gap_q + CW'(SMP);
    err_d = err_q | (gap_d > CW'(LIM));
    if (!en_i) begin
      gap_d = '0;
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      err_q <= 1'b0;
    end else begin
      gap_q <= gap_d;
      err_q <= err_d;
    end
  end

  assign err_o = err_q;

  // R8: sticky inside the window, cleared once the window closes
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && err_o) |=> err_o);
  a_r8_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> !err_o);
endmodule

// File: rtl/ovs_pack.sv
module ovs_pack #(
  parameter int unsigned SMP = 6,
  parameter int unsigned DW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SMP-1:0]    edge_i,
  input  logic [SMP*DW-1:0] dq_i,
  output logic [2*DW-1:0]   data_o,
  output logic [1:0]        vld_o
);
  logic           carry_q, carry_d;
  logic           pend_v_q, pend_v_d;
  logic [DW-1:0]  pend_q, pend_d;
  logic [2*DW-1:0] data_q, data_d;
  logic [1:0]     vld_q, vld_d;
  logic [SMP-1:0] ctr;
  logic [DW-1:0]  item [3];
  logic [1:0]     n;

  // a bit center sits one sample after its edge; sample 0 inherits the last edge
  assign ctr = {edge_i[SMP-2:0], carry_q};

  always_comb begin
    n = 2'd0;
    for (int i = 0; i < 3; i++) item[i] = '0;
    if (pend_v_q) begin
      item[0] = pend_q;
      n       = 2'd1;
    end
    for (int m = 0; m < SMP; m++) begin
      if (ctr[m] && n != 2'd3) begin
        item[n] = dq_i[m*DW +: DW];
        n       = n + 2'd1;
      end
    end
    vld_d    = (n >= 2'd2) ? 2'b11 : ((n == 2'd1) ? 2'b01 : 2'b00);
    data_d   = {item[1], item[0]};
    pend_v_d = (n == 2'd3);
    pend_d   = item[2];
    carry_d  = edge_i[SMP-1];
    if (!en_i) begin
      vld_d    = 2'b00;
      pend_v_d = 1'b0;
      carry_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q  <= 1'b0;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
      data_q   <= '0;
      vld_q    <= 2'b00;
    end else begin
      carry_q  <= carry_d;
      pend_v_q <= pend_v_d;
      vld_q    <= vld_d;
      if (en_i) begin
        pend_q <= pend_d;
        data_q <= data_d;
      end
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;

  // R3: an edge on the final sample is carried into the next group
  a_r3_carry_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && edge_i[SMP-1]) |=> carry_q);
  // R6: a held byte leaves first, in the low lane
  a_r6_pend_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pend_v_q) |=> (vld_o[0] && data_o[DW-1:0] == $past(pend_q)));
  // R7: nothing valid after a closed window
  a_r7_idle_novld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (vld_o == 2'b00));
endmodule

// File: rtl/ovs_ddr_recover.sv
module ovs_ddr_recover #(
  parameter int unsigned SMP = ovs_pkg::OVS_SMP_DEF,
  parameter int unsigned DW  = ovs_pkg::OVS_DW_DEF,
  parameter int unsigned LIM = ovs_pkg::OVS_GAP_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_en_i,
  input  logic [SMP-1:0]    strb_smp_i,
  input  logic [SMP*DW-1:0] dq_smp_i,
  output logic [2*DW-1:0]   rd_data_o,
  output logic [1:0]        rd_vld_o,
  output logic              gap_err_o
);
  logic [SMP-1:0] edges;

  ovs_edge #(.SMP(SMP)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (win_en_i),
    .strb_i (strb_smp_i),
    .edge_o (edges)
  );

  ovs_pack #(.SMP(SMP), .DW(DW)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (win_en_i),
    .edge_i (edges),
    .dq_i   (dq_smp_i),
    .data_o (rd_data_o),
    .vld_o  (rd_vld_o)
  );

  ovs_gapmon #(.SMP(SMP), .LIM(LIM)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (win_en_i),
    .edge_i (edges),
    .err_o  (gap_err_o)
  );

  // R5: the high lane is never valid alone
  a_r5_mask_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o[1] |-> rd_vld_o[0]);
endmodule

// File: tb/ovs_ddr_recover_tb_top.sv
module ovs_ddr_recover_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_en = 1'b0;
  logic [5:0]  strb = '0;
  logic [47:0] dq = '0;
  logic [15:0] rd_data;
  logic [1:0]  rd_vld;
  logic        gap_err;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;
  bit  mon_on = 1'b0;
  bit  bad_mask = 1'b0;
  logic [7:0] got[$];

  always #5 clk = ~clk;

  ovs_ddr_recover dut_i (
    .clk_i(clk), .rst_ni(rst_n), .win_en_i(win_en), .strb_smp_i(strb),
    .dq_smp_i(dq), .rd_data_o(rd_data), .rd_vld_o(rd_vld), .gap_err_o(gap_err)
  );

  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_vld == 2'b10) bad_mask = 1'b1;
      if (rd_vld[0]) got.push_back(rd_data[7:0]);
      if (rd_vld[1]) got.push_back(rd_data[15:8]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [5:0] s, input logic [47:0] d);
    win_en = en; strb = s; dq = d;
    @(posedge clk); #1;
  endtask

  function automatic logic [47:0] rnd48();
    return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
  endfunction

  task automatic t_reset();
    chk(rd_vld == 2'b00 && gap_err == 1'b0, "R1 during reset", {rd_vld, gap_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rd_vld == 2'b00 && gap_err == 1'b0, "R1 after release", {rd_vld, gap_err}, 0);
  endtask

  task automatic t_single_edges();
    logic [47:0] d;
    drive(1'b0, 6'b0, '0);
    d = rnd48(); d[2*8 +: 8] = 8'hA5;
    drive(1'b1, 6'b111110, d);              // rising at sample 1, center 2
    chk(rd_vld == 2'b01 && rd_data[7:0] == 8'hA5, "R2 rising k=1", rd_data[7:0], 8'hA5);
    d = rnd48();
    drive(1'b1, 6'b011111, d);              // falling at sample 5
    chk(rd_vld == 2'b00, "R3 carry not yet out", rd_vld, 0);
    d = rnd48(); d[7:0] = 8'h3C;
    drive(1'b1, 6'b000000, d);
    chk(rd_vld == 2'b01 && rd_data[7:0] == 8'h3C, "R3 carried byte", rd_data[7:0], 8'h3C);
    d = rnd48(); d[1*8 +: 8] = 8'h5A;
    drive(1'b1, 6'b111111, d);              // boundary edge
    chk(rd_vld == 2'b01 && rd_data[7:0] == 8'h5A, "R4 boundary edge", rd_data[7:0], 8'h5A);
  endtask

  task automatic t_three();
    logic [47:0] d;
    d = rnd48(); d[1*8 +: 8] = 8'h11; d[3*8 +: 8] = 8'h22; d[5*8 +: 8] = 8'h33;
    drive(1'b1, 6'b001100, d);              // edges at 0,2,4 with history high
    chk(rd_vld == 2'b11 && rd_data == 16'h2211, "R5 R6 pair order", rd_data, 16'h2211);
    drive(1'b1, 6'b000000, rnd48());
    chk(rd_vld == 2'b01 && rd_data[7:0] == 8'h33, "R6 held byte", rd_data[7:0], 8'h33);
  endtask

  task automatic t_window();
    logic [47:0] d;
    drive(1'b0, 6'b010101, rnd48());
    chk(rd_vld == 2'b00, "R7 no valid when closed", rd_vld, 0);
    drive(1'b0, 6'b111111, rnd48());
    d = rnd48(); d[1*8 +: 8] = 8'h77;
    drive(1'b1, 6'b111111, d);
    chk(rd_vld == 2'b01 && rd_data[7:0] == 8'h77, "R7 history cleared", rd_data[7:0], 8'h77);
  endtask

  task automatic t_gap();
    drive(1'b0, 6'b0, '0);
    drive(1'b1, 6'b0, rnd48());
    drive(1'b1, 6'b0, rnd48());
    chk(gap_err == 1'b0, "R8 12 samples no error", gap_err, 0);
    drive(1'b1, 6'b0, rnd48());
    chk(gap_err == 1'b1, "R8 error after 18 samples", gap_err, 1);
    drive(1'b1, 6'b000111, rnd48());
    chk(gap_err == 1'b1, "R8 sticky", gap_err, 1);
    drive(1'b0, 6'b0, '0);
    chk(gap_err == 1'b0, "R8 clear on close", gap_err, 0);
  endtask

  task automatic t_stream(input int off, input bit jit, input int nb);
    bit         st[96];
    logic [7:0] dv[96];
    int         p[20];
    logic [7:0] b[20];
    int         e, nv, ok;
    bit         lvl;
    logic [47:0] d;
    logic [5:0]  s;
    for (int n = 0; n < 96; n++) dv[n] = 8'($urandom());
    for (int i = 0; i < nb; i++) begin
      p[i] = 6 + off + 3 * i + (jit ? int'($urandom_range(0, 1)) : 0);
      b[i] = 8'($urandom());
    end
    for (int i = 0; i < nb; i++) begin
      int stop;
      stop = (i + 1 < nb) ? p[i+1] : p[i] + 3;
      for (int n = p[i]; n < stop; n++) dv[n] = b[i];
    end
    e = 0; lvl = 1'b0;
    for (int n = 0; n < 96; n++) begin
      if (e < nb && n == p[e]) begin lvl = ~lvl; e++; end
      st[n] = lvl;
    end
    nv = (p[nb-1] + 1) / 6 + 2;
    drive(1'b0, 6'b0, '0);
    got.delete(); bad_mask = 1'b0; mon_on = 1'b1;
    for (int v = 0; v < nv; v++) begin
      for (int k = 0; k < 6; k++) begin
        s[k] = st[6*v + k];
        d[8*k +: 8] = dv[6*v + k];
      end
      drive(1'b1, s, d);
    end
    drive(1'b0, 6'b0, '0);
    @(negedge clk); #1;
    mon_on = 1'b0;
    chk(got.size() == nb, $sformatf("R9 count off=%0d jit=%0d", off, jit), got.size(), nb);
    ok = 1;
    if (got.size() == nb) begin
      for (int i = 0; i < nb; i++) begin
        if (got[i] !== b[i]) begin
          ok = 0;
          chk(1'b0, $sformatf("R9 byte %0d off=%0d jit=%0d", i, off, jit), got[i], b[i]);
        end
      end
    end
    if (ok) chk(1'b1, "R9 bytes", 0, 0);
    chk(!bad_mask, "R5 mask in stream", bad_mask, 0);
    chk(gap_err == 1'b0, "R8 no error in stream", gap_err, 0);
  endtask

  initial begin
    t_reset();
    t_single_edges();
    t_three();
    t_window();
    t_gap();
    for (int off = 0; off < 6; off++) begin
      t_stream(off, 1'b0, 20);
      t_stream(off, 1'b1, 20);
      t_stream(off, 1'b1, 20);
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule